// File: doc/BRIEF.md
# Multiprocessor-Format Serial Transmitter

This block is the transmit half of an asynchronous serial port whose frames carry one extra marker bit. The marker tells receivers whether the frame holds an address or data. Software writes a byte into a holding register. It then clears the data-empty flag to say that the byte is valid. On a baud tick the block copies the byte into its own shift register, sets the data-empty flag again so that software can queue the next byte, and drives the frame onto a single registered line.

Each frame goes out in a fixed order: a low start bit, the data bits least-significant first (7 or 8 of them), the marker bit, then one or two high stop bits. A bit lasts exactly one period of the external baud tick. When the last stop bit begins, the block looks at the data-empty flag. If software has queued another byte, that byte is loaded at once and its start bit follows the stop bit with no idle time. If nothing is queued, the transmit-end flag is set and the line rests high. Each flag drives an interrupt level through its own enable.

Top module: `mpx_uart_tx`

## Requirements
- R1: After reset, txd is 1, empty_flag is 1 and end_flag is 1.
- R2: A frame is a start bit at 0, then the data bits, then a marker bit equal to mpb_bit as sampled at load, then the stop bits at 1. Each bit is held for exactly one baud_tick period.
- R3: With short_len=1 as sampled at load, 7 data bits (hold_din[6:0]) are sent. With short_len=0, 8 bits are sent. In both cases bit 0 goes first.
- R4: With two_stop=1 as sampled at load, two stop bits are sent. With two_stop=0, one is sent.
- R5: A pulse on empty_clr makes empty_flag 0 and end_flag 0. While the line is idle and empty_flag is 0, the next baud_tick copies the holding register, sets empty_flag to 1 and starts the start bit.
- R6: If empty_flag is 0 when the last stop bit begins, the next frame is loaded there: empty_flag goes to 1 and end_flag stays 0. The next start bit directly follows that stop bit.
- R7: If empty_flag is 1 when the last stop bit begins, end_flag goes to 1 in that same cycle. After the stop bit the line stays 1.
- R8: irq_empty equals empty_flag AND txi_en. irq_end equals end_flag AND tei_en.
- R9: With tx_en=0, txd is 1 from the next cycle on, a frame in progress is abandoned, and no frame starts even if empty_flag is 0.
- R10: txd is registered. It changes only in the cycle after a baud_tick, or after tx_en goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| tx_en | input | 1 | Transmit enable; 0 holds the line idle |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_din | input | DATA_W | Byte to write into the holding register |
| empty_clr | input | 1 | Clears empty_flag and end_flag (new byte queued) |
| short_len | input | 1 | 1 = 7 data bits, 0 = 8; sampled at load |
| two_stop | input | 1 | 1 = two stop bits; sampled at load |
| mpb_bit | input | 1 | Marker bit value for the frame; sampled at load |
| txi_en | input | 1 | Enable for the data-empty interrupt |
| tei_en | input | 1 | Enable for the transmit-end interrupt |
| txd | output | 1 | Serial line, idles at 1 |
| empty_flag | output | 1 | Holding register free for a new byte |
| end_flag | output | 1 | Transmission finished, line idle |
| irq_empty | output | 1 | Data-empty interrupt level |
| irq_end | output | 1 | Transmit-end interrupt level |

## Verification
The hardest case to reach is the hand-off at the start of the last stop bit. There the next frame is loaded while the current frame still has a bit to send, so the new frame's length, stop count and marker have to be latched without disturbing the bits already committed. The stimulus reaches this case with random chains of frames. Each next byte, with new random settings, is queued right after the current start bit, so the settings change under a frame in flight. A disable during a frame, and a clear made while disabled, force the abandon and no-start paths.

// File: rtl/mpx_uart_tx_pkg.sv
package mpx_uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_MPB,
        ST_STOP
    } tx_state_e;

    // Per-frame settings latched together with the data byte
    typedef struct packed {
        logic short_len;
        logic two_stop;
        logic mpb;
    } frame_cfg_t;

    // Number of data bits for a frame given the full width
    function automatic int unsigned data_bits(input logic short_len, input int unsigned full_w);
        return short_len ? full_w - 1 : full_w;
    endfunction

endpackage

// File: rtl/mpx_uart_tx_hold.sv
module mpx_uart_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wr_data;
        end
    end
endmodule

// File: rtl/mpx_uart_tx_flags.sv
module mpx_uart_tx_flags (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic load,
    input  logic end_set,
    input  logic txi_en,
    input  logic tei_en,
    output logic empty,
    output logic done,
    output logic irq_empty,
    output logic irq_end
);
    always_ff @(posedge clk) begin
        if (rst) begin
            empty <= 1'b1;
            done  <= 1'b1;
        end else begin
            // a load only happens while empty is 0, so load wins over clr
            if (load) begin
                empty <= 1'b1;
            end else if (clr) begin
                empty <= 1'b0;
            end
            if (clr) begin
                done <= 1'b0;
            end else if (end_set) begin
                done <= 1'b1;
            end
        end
    end

    assign irq_empty = empty & txi_en;
    assign irq_end   = done & tei_en;
endmodule

// File: rtl/mpx_uart_tx_seq.sv
module mpx_uart_tx_seq
    import mpx_uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  logic              empty,
    input  logic [DATA_W-1:0] hold_data,
    input  frame_cfg_t        cfg_in,
    output logic              load,
    output logic              end_set,
    output logic              txd
);
    localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

    tx_state_e         state_q;
    logic [DATA_W-1:0] shreg_q;
    frame_cfg_t        cfg_q;
    logic [IDX_W-1:0]  bit_idx_q;
    logic [IDX_W-1:0]  last_idx;
    logic              in_last_q;
    logic              pending_q;
    logic              txd_q;
    logic              enter_last;
    logic              idle_load;

    always_comb begin
        last_idx   = IDX_W'(data_bits(cfg_q.short_len, DATA_W) - 1);
        // this tick starts the final stop bit of the current frame
        enter_last = baud_tick && tx_en &&
                     (((state_q == ST_MPB) && !cfg_q.two_stop) ||
                      ((state_q == ST_STOP) && !in_last_q));
        idle_load  = baud_tick && tx_en && (state_q == ST_IDLE) && !empty;
        load       = idle_load || (enter_last && !empty);
        end_set    = enter_last && empty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            shreg_q   <= '0;
            cfg_q     <= '0;
            bit_idx_q <= '0;
            in_last_q <= 1'b0;
            pending_q <= 1'b0;
            txd_q     <= 1'b1;
        end else if (!tx_en) begin
            state_q   <= ST_IDLE;
            in_last_q <= 1'b0;
            pending_q <= 1'b0;
            txd_q     <= 1'b1;
        end else begin
            if (load) begin
                shreg_q <= hold_data;
                cfg_q   <= cfg_in;
            end
            if (baud_tick) begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (!empty) begin
                            state_q <= ST_START;
                            txd_q   <= 1'b0;
                        end
                    end
                    ST_START: begin
                        state_q   <= ST_DATA;
                        txd_q     <= shreg_q[0];
                        shreg_q   <= shreg_q >> 1;
                        bit_idx_q <= '0;
                    end
                    ST_DATA: begin
                        if (bit_idx_q == last_idx) begin
                            state_q <= ST_MPB;
                            txd_q   <= cfg_q.mpb;
                        end else begin
                            txd_q     <= shreg_q[0];
                            shreg_q   <= shreg_q >> 1;
                            bit_idx_q <= bit_idx_q + IDX_W'(1);
                        end
                    end
                    ST_MPB: begin
                        state_q   <= ST_STOP;
                        txd_q     <= 1'b1;
                        in_last_q <= !cfg_q.two_stop;
                        pending_q <= !cfg_q.two_stop && !empty;
                    end
                    ST_STOP: begin
                        if (in_last_q) begin
                            in_last_q <= 1'b0;
                            if (pending_q) begin
                                state_q <= ST_START;
                                txd_q   <= 1'b0;
                            end else begin
                                state_q <= ST_IDLE;
                                txd_q   <= 1'b1;
                            end
                        end else begin
                            in_last_q <= 1'b1;
                            pending_q <= !empty;
                            txd_q     <= 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign txd = txd_q;
endmodule

// File: rtl/mpx_uart_tx.sv
module mpx_uart_tx
    import mpx_uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  logic              hold_wr,
    input  logic [DATA_W-1:0] hold_din,
    input  logic              empty_clr,
    input  logic              short_len,
    input  logic              two_stop,
    input  logic              mpb_bit,
    input  logic              txi_en,
    input  logic              tei_en,
    output logic              txd,
    output logic              empty_flag,
    output logic              end_flag,
    output logic              irq_empty,
    output logic              irq_end
);
    logic [DATA_W-1:0] hold_q;
    logic              load;
    logic              end_set;
    frame_cfg_t        cfg_in;

    assign cfg_in = '{short_len: short_len, two_stop: two_stop, mpb: mpb_bit};

    mpx_uart_tx_hold #(.DATA_W(DATA_W)) hold_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (hold_wr),
        .wr_data (hold_din),
        .q       (hold_q)
    );

    mpx_uart_tx_flags flags_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (empty_clr),
        .load      (load),
        .end_set   (end_set),
        .txi_en    (txi_en),
        .tei_en    (tei_en),
        .empty     (empty_flag),
        .done      (end_flag),
        .irq_empty (irq_empty),
        .irq_end   (irq_end)
    );

    mpx_uart_tx_seq #(.DATA_W(DATA_W)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .baud_tick (baud_tick),
        .tx_en     (tx_en),
        .empty     (empty_flag),
        .hold_data (hold_q),
        .cfg_in    (cfg_in),
        .load      (load),
        .end_set   (end_set),
        .txd       (txd)
    );
endmodule

// File: rtl/mpx_uart_tx_chk.sv
module mpx_uart_tx_chk (
    input logic clk,
    input logic rst,
    input logic baud_tick,
    input logic tx_en,
    input logic empty_clr,
    input logic txd,
    input logic empty_flag,
    input logic end_flag
);
    // R1
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (txd && empty_flag && end_flag));

    // R5
    a_r5_clear_flags: assert property (@(posedge clk) disable iff (rst)
        (empty_clr && empty_flag) |=> (!empty_flag && !end_flag));

    // R5, R6: the flag goes back to 1 only on a load, which is tick-driven
    a_r6_load_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(empty_flag) |-> ($past(baud_tick) && $past(tx_en)));

    // R7
    a_r7_end_on_mark: assert property (@(posedge clk) disable iff (rst)
        $rose(end_flag) |-> (txd && $past(baud_tick)));

    // R9
    a_r9_disable_mark: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> txd);

    // R10
    a_r10_txd_on_tick: assert property (@(posedge clk) disable iff (rst)
        !$stable(txd) |-> ($past(baud_tick) || !$past(tx_en)));
endmodule

bind mpx_uart_tx mpx_uart_tx_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .baud_tick  (baud_tick),
    .tx_en      (tx_en),
    .empty_clr  (empty_clr),
    .txd        (txd),
    .empty_flag (empty_flag),
    .end_flag   (end_flag)
);

// File: tb/mpx_uart_tx_tb_top.sv
module mpx_uart_tx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 3;
    localparam int WD_LIMIT   = 150000;

    logic       clk = 1'b0;
    logic       rst, baud_tick, tx_en, hold_wr, empty_clr;
    logic [7:0] hold_din;
    logic       short_len, two_stop, mpb_bit, txi_en, tei_en;
    logic       txd, empty_flag, end_flag, irq_empty, irq_end;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    logic [7:0] fd[8];
    logic       fs[8], ft[8], fm[8];

    always #(CLK_PERIOD/2) clk = ~clk;

    mpx_uart_tx #(.DATA_W(8)) dut_i (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .tx_en(tx_en),
        .hold_wr(hold_wr), .hold_din(hold_din), .empty_clr(empty_clr),
        .short_len(short_len), .two_stop(two_stop), .mpb_bit(mpb_bit),
        .txi_en(txi_en), .tei_en(tei_en), .txd(txd), .empty_flag(empty_flag),
        .end_flag(end_flag), .irq_empty(irq_empty), .irq_end(irq_end)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // expected line value of bit position idx within a frame
    function automatic logic exp_bit(input logic [7:0] d, input logic sl, input logic mpb, input int idx);
        int len = sl ? 7 : 8;
        if (idx == 0) return 1'b0;
        if (idx <= len) return d[idx-1];
        if (idx == len + 1) return mpb;
        return 1'b1;
    endfunction

    function automatic int frame_len(input logic sl, input logic ts);
        return 1 + (sl ? 7 : 8) + 1 + (ts ? 2 : 1);
    endfunction

    function automatic string bit_tag(input logic sl, input int idx);
        int len = sl ? 7 : 8;
        if (idx == 0) return "R2 start";
        if (idx <= len) return "R3 data";
        if (idx == len + 1) return "R2 marker";
        return "R4 stop";
    endfunction

    // one baud tick; returns the line value for the bit it begins
    task automatic tick(output logic v);
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
        v = txd;
    endtask

    task automatic gap(input logic v);
        logic stable = 1'b1;
        repeat (GAP) begin
            @(negedge clk);
            if (txd !== v) stable = 1'b0;
        end
        chk("R10 line held between ticks", stable, 1'b1);
    endtask

    task automatic sw_queue(input logic [7:0] d);
        hold_wr = 1'b1; hold_din = d;
        @(negedge clk);
        hold_wr = 1'b0; empty_clr = 1'b1;
        @(negedge clk);
        empty_clr = 1'b0;
    endtask

    task automatic set_cfg(input int i);
        short_len = fs[i]; two_stop = ft[i]; mpb_bit = fm[i];
    endtask

    // send n frames back to back; preloaded: frame 0 is already queued
    task automatic run_frames(input int n, input bit preloaded);
        logic v;
        set_cfg(0);
        if (!preloaded) begin
            sw_queue(fd[0]);
            chk("R5 clear empty", empty_flag, 1'b0);
            chk("R5 clear end", end_flag, 1'b0);
        end
        tick(v);
        chk("R2 first start", v, 1'b0);
        chk("R5 empty after load", empty_flag, 1'b1);
        for (int i = 0; i < n; i++) begin
            int nb = frame_len(fs[i], ft[i]);
            if (i + 1 < n) begin
                set_cfg(i + 1);
                sw_queue(fd[i + 1]);
            end
            gap(txd);
            for (int b = 1; b < nb; b++) begin
                tick(v);
                chk(bit_tag(fs[i], b), v, exp_bit(fd[i], fs[i], fm[i], b));
                if (b == nb - 1) begin
                    if (i + 1 < n) chk("R6 no end on chained frame", end_flag, 1'b0);
                    else           chk("R7 end at last stop", end_flag, 1'b1);
                    chk("R6 empty at last stop", empty_flag, 1'b1);
                end
                gap(v);
            end
            tick(v);
            if (i + 1 < n) begin
                chk("R6 start follows stop", v, 1'b0);
            end else begin
                chk("R7 line idle after end", v, 1'b1);
                chk("R7 end held", end_flag, 1'b1);
            end
            gap(v);
        end
    endtask

    initial begin
        logic v;
        void'($urandom(32'h1a2b3c4d));
        rst = 1'b1; baud_tick = 1'b0; tx_en = 1'b1; hold_wr = 1'b0; hold_din = '0;
        empty_clr = 1'b0; short_len = 1'b0; two_stop = 1'b0; mpb_bit = 1'b0;
        txi_en = 1'b1; tei_en = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 txd", txd, 1'b1);
        chk("R1 empty", empty_flag, 1'b1);
        chk("R1 end", end_flag, 1'b1);
        chk("R8 irq_empty on", irq_empty, 1'b1);
        chk("R8 irq_end on", irq_end, 1'b1);
        txi_en = 1'b0; tei_en = 1'b0;
        #1;
        chk("R8 irq_empty off", irq_empty, 1'b0);
        chk("R8 irq_end off", irq_end, 1'b0);
        tick(v);
        chk("R5 idle without clear", v, 1'b1);

        // directed: 8 bits, one stop, marker 1
        fd[0] = 8'hA5; fs[0] = 1'b0; ft[0] = 1'b0; fm[0] = 1'b1;
        run_frames(1, 1'b0);
        // directed: 7 bits, two stops, marker 0, bit 7 set must not appear
        fd[0] = 8'hC3; fs[0] = 1'b1; ft[0] = 1'b1; fm[0] = 1'b0;
        fd[1] = 8'h7E; fs[1] = 1'b0; ft[1] = 1'b1; fm[1] = 1'b1;
        run_frames(2, 1'b0);

        // random chains
        for (int r = 0; r < 12; r++) begin
            int n = 1 + int'($urandom % 6);
            for (int k = 0; k < n; k++) begin
                fd[k] = 8'($urandom);
                fs[k] = 1'($urandom);
                ft[k] = 1'($urandom);
                fm[k] = 1'($urandom);
            end
            txi_en = 1'($urandom);
            tei_en = 1'($urandom);
            run_frames(n, 1'b0);
            #1;
            chk("R8 irq_empty level", irq_empty, txi_en);
            chk("R8 irq_end level", irq_end, tei_en);
        end

        // disable in mid-frame
        fd[0] = 8'h00; fs[0] = 1'b0; ft[0] = 1'b0; fm[0] = 1'b0;
        set_cfg(0);
        sw_queue(fd[0]);
        tick(v);
        chk("R2 start before abort", v, 1'b0);
        tick(v);
        tx_en = 1'b0;
        @(negedge clk);
        chk("R9 line forced high", txd, 1'b1);
        repeat (3) begin
            tick(v);
            chk("R9 stays high while off", v, 1'b1);
        end
        tx_en = 1'b1;
        tick(v);
        chk("R9 no restart of abandoned frame", v, 1'b1);

        // clear while disabled: nothing starts until enabled
        tx_en = 1'b0;
        fd[0] = 8'h96; fs[0] = 1'b1; ft[0] = 1'b0; fm[0] = 1'b1;
        set_cfg(0);
        sw_queue(fd[0]);
        repeat (2) begin
            tick(v);
            chk("R9 no start while off", v, 1'b1);
            chk("R9 data stays queued", empty_flag, 1'b0);
        end
        tx_en = 1'b1;
        @(negedge clk);
        run_frames(1, 1'b1);

        summary();
        $finish;
    end
endmodule